// File: doc/BRIEF.md
# Square-Root Partitioned Carry-Select Adder

This block adds two unsigned operands and a carry-in without any clock, returning a sum of the same width and a carry-out. The lowest two bits form a small ripple-carry group fed directly by the adder's carry-in. Everything above is divided into carry-select groups. Their widths grow toward the most significant end, so the time a carry takes to ripple inside a group roughly matches the time the select signal takes to arrive from below.

Inside each carry-select group, the propagate word (a xor b) and the generate word (a and b) feed two carry chains at once. One chain assumes a group carry-in of 0 and the other assumes 1. The real group carry-in picks one of the two carry words. A single sum word is then formed by XORing the propagate word with the chosen carries shifted up one place. No second sum word is ever built.

A package enumeration selects the partition. The default is a 64-bit partition. The alternative is a 16-bit partition. If the width parameter does not equal the total of the selected group sizes, elaboration stops with an error.

Top module: `msqrt_csla_adder`

## Requirements
- R1: With the default 64-bit partition, {cout_o, sum_o} equals a_i + b_i + cin_i taken as a 65-bit unsigned value, for any operands.
- R2: With the 16-bit partition selected, {cout_o, sum_o} equals a_i + b_i + cin_i taken as a 17-bit unsigned value.
- R3: Bit 0 of sum_o equals a_i[0] xor b_i[0] xor cin_i, because the two-bit ripple group at the bottom takes the adder carry-in directly.
- R4: Group sizes from bit 0 upward are 2, 2, 3, 4, 6, 7, 8, 9, 11, 12 for 64 bits and 2, 2, 3, 4, 5 for 16 bits. The carry entering each group equals the carry out of the sum of all bits below it. Adding an operand with ones in bits p-1..0 to zero with cin_i = 1 yields exactly 1 << p at every group boundary p.
- R5: cout_o is the carry out of the most significant group. An all-ones operand plus zero with cin_i = 1 gives sum_o = 0 and cout_o = 1.
- R6: When a_i and b_i share no set bit and cin_i = 0, sum_o equals a_i or b_i and cout_o is 0.
- R7: When b_i is the bitwise complement of a_i, the result is all ones with cout_o = 0 for cin_i = 0, and zero with cout_o = 1 for cin_i = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH (64) | First operand |
| b_i | input | WIDTH (64) | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH (64) | Sum word |
| cout_o | output | 1 | Carry out of the top group |

## Verification
The case of interest puts two events in the same evaluation. A carry leaves the ripple group or a lower select group and ripples to a group boundary, and in that same evaluation every higher group must switch from its chain-0 carry word to its chain-1 word. Operands that are all ones below a chosen boundary, or complementary patterns with a carry-in of 1, force this at every boundary and in every group together. Each result is compared with an arithmetic reference sum, and the carry entering each group is compared with the carry of the partial sum below it.

// File: rtl/msqrt_csla_pkg.sv
package msqrt_csla_pkg;

    typedef enum logic [0:0] {
        PART_W64 = 1'b0,
        PART_W16 = 1'b1
    } part_e;

    localparam int unsigned MAX_GROUPS = 10;

    function automatic int unsigned grp_count(part_e p);
        return (p == PART_W16) ? 5 : 10;
    endfunction

    function automatic int unsigned grp_size(part_e p, int unsigned idx);
        int unsigned s;
        s = 0;
        if (p == PART_W16) begin
            case (idx)
                0: s = 2;
                1: s = 2;
                2: s = 3;
                3: s = 4;
                4: s = 5;
                default: s = 0;
            endcase
        end else begin
            case (idx)
                0: s = 2;
                1: s = 2;
                2: s = 3;
                3: s = 4;
                4: s = 6;
                5: s = 7;
                6: s = 8;
                7: s = 9;
                8: s = 11;
                9: s = 12;
                default: s = 0;
            endcase
        end
        return s;
    endfunction

    // Bit position where group idx starts (sum of all sizes below it).
    function automatic int unsigned grp_lsb(part_e p, int unsigned idx);
        int unsigned s;
        s = 0;
        for (int unsigned k = 0; k < MAX_GROUPS; k++) begin
            if (k < idx) s += grp_size(p, k);
        end
        return s;
    endfunction

    function automatic int unsigned part_width(part_e p);
        return grp_lsb(p, grp_count(p));
    endfunction

endpackage

// File: rtl/msqrt_csla_ripple.sv
module msqrt_csla_ripple #(
    parameter int unsigned W = 2
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);

    logic [W-1:0] sum_d;
    logic         cout_d;

    always_comb begin
        logic c;
        c = cin_i;
        for (int i = 0; i < int'(W); i++) begin
            sum_d[i] = a_i[i] ^ b_i[i] ^ c;
            c        = (a_i[i] & b_i[i]) | ((a_i[i] ^ b_i[i]) & c);
        end
        cout_d = c;
    end

    assign sum_o  = sum_d;
    assign cout_o = cout_d;

endmodule

// File: rtl/msqrt_csla_select_group.sv
module msqrt_csla_select_group #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);

    logic [W-1:0] hsum_d;
    logic [W-1:0] hcar_d;
    logic [W-1:0] csel_d;
    logic [W-1:0] sum_d;

    assign hsum_d = a_i ^ b_i;
    assign hcar_d = a_i & b_i;

    // Carry chain with a fixed seed; a local variable carries the ripple.
    function automatic logic [W-1:0] carry_word(logic [W-1:0] hs,
                                                logic [W-1:0] hc,
                                                logic         seed);
        logic [W-1:0] w;
        logic         c;
        c = seed;
        for (int i = 0; i < int'(W); i++) begin
            c    = (c & hs[i]) | hc[i];
            w[i] = c;
        end
        return w;
    endfunction

    // Both anticipated carry words, one per assumed group carry-in.
    logic [W-1:0] chain_d [2];

    for (genvar k = 0; k < 2; k++) begin : g_chain
        assign chain_d[k] = carry_word(hsum_d, hcar_d, 1'(k));
    end

    // Select the carry word first, then form a single sum word.
    assign csel_d = cin_i ? chain_d[1] : chain_d[0];

    always_comb begin
        sum_d[0] = hsum_d[0] ^ cin_i;
        for (int i = 1; i < int'(W); i++) begin
            sum_d[i] = hsum_d[i] ^ csel_d[i-1];
        end
    end

    assign sum_o  = sum_d;
    assign cout_o = csel_d[W-1];

endmodule

// File: rtl/msqrt_csla_adder.sv
module msqrt_csla_adder
    import msqrt_csla_pkg::*;
#(
    parameter part_e       PART  = PART_W64,
    parameter int unsigned WIDTH = part_width(PART)
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    localparam int unsigned NGRP = grp_count(PART);

    if (WIDTH != part_width(PART)) begin : g_bad_width
        $error("group sizes of the selected partition do not add up to WIDTH");
    end

    // grp_carry[g] is the carry entering group g; the last entry leaves the top.
    logic [NGRP:0] grp_carry;

    assign grp_carry[0] = cin_i;

    for (genvar g = 0; g < int'(NGRP); g++) begin : g_grp
        localparam int unsigned LSB = grp_lsb(PART, g);
        localparam int unsigned GW  = grp_size(PART, g);
        if (g == 0) begin : g_rip
            msqrt_csla_ripple #(.W(GW)) u_rip (
                .a_i   (a_i[LSB +: GW]),
                .b_i   (b_i[LSB +: GW]),
                .cin_i (grp_carry[g]),
                .sum_o (sum_o[LSB +: GW]),
                .cout_o(grp_carry[g+1])
            );
        end else begin : g_sel
            msqrt_csla_select_group #(.W(GW)) u_sel (
                .a_i   (a_i[LSB +: GW]),
                .b_i   (b_i[LSB +: GW]),
                .cin_i (grp_carry[g]),
                .sum_o (sum_o[LSB +: GW]),
                .cout_o(grp_carry[g+1])
            );
        end
    end

    assign cout_o = grp_carry[NGRP];

endmodule

// File: rtl/msqrt_csla_adder_chk.sv
module msqrt_csla_adder_chk
    import msqrt_csla_pkg::*;
#(
    parameter part_e       PART  = PART_W64,
    parameter int unsigned WIDTH = part_width(PART),
    localparam int unsigned NGRP = grp_count(PART)
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             cin_i,
    input logic [WIDTH-1:0] sum_o,
    input logic             cout_o,
    input logic [NGRP:0]    grp_carry
);

    always_comb begin
        logic [WIDTH:0]   ref_v;
        logic [WIDTH:0]   part_v;
        logic [WIDTH-1:0] m;
        int unsigned      lsb;

        ref_v = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

        // R1 / R2: arithmetic result for the selected partition
        a_r1_r2_sum_matches: assert ({cout_o, sum_o} == ref_v)
            else $error("sum mismatch");

        // R3: bottom bit uses the adder carry-in
        a_r3_lsb_bit: assert (sum_o[0] == (a_i[0] ^ b_i[0] ^ cin_i))
            else $error("bit 0 mismatch");

        // R6: no generate, no carry-in
        if (!cin_i && ((a_i & b_i) == '0)) begin
            a_r6_no_carry: assert (sum_o == (a_i | b_i) && !cout_o)
                else $error("carry-free sum wrong");
        end

        // R7: propagate-only operands
        if ((a_i ^ b_i) == '1) begin
            a_r7_full_propagate: assert (cin_i ? ({cout_o, sum_o} == {1'b1, {WIDTH{1'b0}}})
                                              : ({cout_o, sum_o} == {1'b0, {WIDTH{1'b1}}}))
                else $error("propagate pattern wrong");
        end

        // R4 / R5: carry into every group matches the partial sum below it
        for (int unsigned g = 1; g <= NGRP; g++) begin
            lsb = grp_lsb(PART, g);
            for (int unsigned j = 0; j < WIDTH; j++) m[j] = (j < lsb);
            part_v = {1'b0, a_i & m} + {1'b0, b_i & m} + {{WIDTH{1'b0}}, cin_i};
            a_r4_r5_group_carry: assert (grp_carry[g] == part_v[lsb])
                else $error("group carry %0d wrong", g);
        end
    end

endmodule

bind msqrt_csla_adder msqrt_csla_adder_chk #(.PART(PART), .WIDTH(WIDTH)) chk_i (
    .a_i      (a_i),
    .b_i      (b_i),
    .cin_i    (cin_i),
    .sum_o    (sum_o),
    .cout_o   (cout_o),
    .grp_carry(grp_carry)
);

// File: tb/msqrt_csla_adder_tb_top.sv
module msqrt_csla_adder_tb_top;
    import msqrt_csla_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [63:0] a64, b64, s64;
    logic        c64, co64;
    logic [15:0] a16, b16, s16;
    logic        c16, co16;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    msqrt_csla_adder dut_i (
        .a_i(a64), .b_i(b64), .cin_i(c64), .sum_o(s64), .cout_o(co64)
    );

    msqrt_csla_adder #(.PART(PART_W16)) dut16_i (
        .a_i(a16), .b_i(b16), .cin_i(c16), .sum_o(s16), .cout_o(co16)
    );

    typedef struct packed {
        logic [63:0] a;
        logic [63:0] b;
        logic        ci;
        logic [63:0] s;
        logic        co;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, 64'h0, 1'b1},
        '{64'h0, 64'h0, 1'b0, 64'h0, 1'b0},
        '{64'h0, 64'h0, 1'b1, 64'h1, 1'b0},
        '{64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
        '{64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b1, 64'h0, 1'b1},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1},
        '{64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 64'h0, 1'b1},
        '{64'h0000_0000_FFFF_FFFF, 64'h1, 1'b0, 64'h0000_0001_0000_0000, 1'b0},
        '{64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 1'b0, 64'h2222_2222_2222_2211, 1'b0}
    };

    localparam int SZ64 [10] = '{2, 2, 3, 4, 6, 7, 8, 9, 11, 12};
    localparam int SZ16 [5]  = '{2, 2, 3, 4, 5};

    task automatic check(string req, logic [64:0] act, logic [64:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run64(string req, logic [63:0] a, logic [63:0] b, logic ci,
                         logic [64:0] exp);
        @(posedge clk);
        a64 = a; b64 = b; c64 = ci;
        @(negedge clk);
        check(req, {co64, s64}, exp);
    endtask

    task automatic run16(string req, logic [15:0] a, logic [15:0] b, logic ci,
                         logic [16:0] exp);
        @(posedge clk);
        a16 = a; b16 = b; c16 = ci;
        @(negedge clk);
        check(req, {48'h0, co16, s16}, {48'h0, exp});
    endtask

    initial begin
        a64 = '0; b64 = '0; c64 = 1'b0;
        a16 = '0; b16 = '0; c16 = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state: quiet inputs give a zero result
        check("R1 reset", {co64, s64}, 65'h0);
        check("R2 reset", {48'h0, co16, s16}, 65'h0);
        rst_n = 1'b1;

        // table walk (R1, R5, R6, R7 patterns among them)
        for (int i = 0; i < NV; i++) begin
            run64("R1 table", VECS[i].a, VECS[i].b, VECS[i].ci, {VECS[i].co, VECS[i].s});
        end

        // R5: all ones plus carry-in clears the sum and raises carry-out
        run64("R5 top carry", '1, '0, 1'b1, {1'b1, 64'h0});

        // R3: bottom bit for each input combination
        for (int k = 0; k < 8; k++) begin
            logic [64:0] e;
            e = {1'b0, 63'h0, k[0]} + {1'b0, 63'h0, k[1]} + {64'h0, k[2]};
            run64("R3 lsb", {63'h0, k[0]}, {63'h0, k[1]}, k[2], e);
        end

        // R4: carry crossing every group boundary, 64-bit partition
        begin
            int p;
            p = 0;
            for (int g = 0; g < 9; g++) begin
                logic [63:0] m;
                p += SZ64[g];
                m = (64'h1 << p) - 64'h1;
                run64("R4 boundary cin", m, 64'h0, 1'b1, {1'b0, 64'h1 << p});
                run64("R4 boundary b", m, 64'h1, 1'b0, {1'b0, 64'h1 << p});
            end
        end

        // R4 on the 16-bit partition
        begin
            int p;
            p = 0;
            for (int g = 0; g < 4; g++) begin
                logic [15:0] m;
                p += SZ16[g];
                m = (16'h1 << p) - 16'h1;
                run16("R4 boundary16", m, 16'h0, 1'b1, {1'b0, 16'h1 << p});
            end
        end

        // R6 and R7 with generated patterns
        for (int i = 0; i < 40; i++) begin
            logic [63:0] x, y;
            x = {$urandom, $urandom};
            y = {$urandom, $urandom} & ~x;
            run64("R6 no carry", x, y, 1'b0, {1'b0, x | y});
            run64("R7 propagate", x, ~x, i[0], i[0] ? {1'b1, 64'h0} : {1'b0, 64'hFFFF_FFFF_FFFF_FFFF});
        end

        // R2: 16-bit partition corners and random
        run16("R2 ones", 16'hFFFF, 16'h0, 1'b1, 17'h10000);
        run16("R2 alt", 16'hAAAA, 16'h5555, 1'b1, 17'h10000);
        for (int i = 0; i < 1500; i++) begin
            logic [15:0] x, y;
            logic        ci;
            x = 16'($urandom); y = 16'($urandom); ci = 1'($urandom);
            run16("R2 random", x, y, ci, {1'b0, x} + {1'b0, y} + {16'h0, ci});
        end

        // R1: random 64-bit operands
        for (int i = 0; i < 1500; i++) begin
            logic [63:0] x, y;
            logic        ci;
            x = {$urandom, $urandom}; y = {$urandom, $urandom}; ci = 1'($urandom);
            run64("R1 random", x, y, ci, {1'b0, x} + {1'b0, y} + {64'h0, ci});
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule